// File: doc/BRIEF.md
# Capture/Compare Channel Flag Unit

This block is a single capture/compare channel that sits beside a free-running counter. The counter value comes in on a port. When the channel is set to capture, a qualified edge event latches that value into a capture register and raises the channel's pending flag. When the channel is set to compare, the pending flag rises whenever the counter equals a compare value. Edge qualification and the counter itself are outside this block.

A second flag records lost captures. A capture that arrives while the pending flag is still set raises the overcapture flag. Software reaches both flags and the two bytes of the capture register over a small 8-bit bus. Writing a zero to a flag bit clears it and writing a one leaves it alone. Reading the low capture byte also clears the pending flag. A one-cycle generate strobe forces an event in either mode. The interrupt request is the pending flag gated by an enable input.

Top module: `cc_chan_top`

## Requirements
- R1: With `in_mode_i`=1, a cycle with `cap_evt_i`=1 loads `cnt_i` into the capture register and sets the capture flag, both visible after that clock edge.
- R2: With `in_mode_i`=0, the capture flag is set after any edge at which `cnt_i` equals `cmp_val_i`, and the capture register keeps its value whatever `cap_evt_i` does.
- R3: The overcapture flag is set only by a capture in input mode (hardware event or generate strobe) that occurs while the capture flag is already 1. It never sets in output mode.
- R4: A bus write to address 0 clears the capture flag when data bit 0 is 0 and clears the overcapture flag when data bit 1 is 0. A data bit of 1 leaves the matching flag unchanged.
- R5: A read strobe at address 2 (low byte) clears the capture flag. A read strobe at address 1 (high byte) does not change it.
- R6: A one-cycle `gen_i` pulse sets the capture flag in output mode. In input mode it also loads `cnt_i` into the capture register and sets overcapture if the capture flag was already 1.
- R7: When a set and a clear of a flag fall in the same cycle, the set wins.
- R8: `irq_o` equals the capture flag ANDed with `irq_en_i`.
- R9: After reset, both flags and the capture register are 0.
- R10: `bus_rdata_o` is combinational from the selected address: address 0 gives {6'b0, overcapture, capture flag}, address 1 gives capture bits [15:8], address 2 gives bits [7:0], and address 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Current counter value |
| cmp_val_i | input | 16 | Compare value for output mode |
| in_mode_i | input | 1 | 1 = input capture, 0 = output compare |
| cap_evt_i | input | 1 | Qualified capture event, one cycle per event |
| gen_i | input | 1 | Software generate strobe, one cycle |
| irq_en_i | input | 1 | Interrupt enable |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (side effect on low byte) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| cap_flag_o | output | 1 | Capture/match pending flag |
| ovr_flag_o | output | 1 | Overcapture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the read and write strobes are never active together and that the mode select stays steady for at least one cycle around each event. The stimulus holds `bus_wr_i` and `bus_rd_i` mutually exclusive and changes `in_mode_i` only on quiet cycles. The bench also keeps `cnt_i` different from `cmp_val_i` in output mode, except when it is testing a match, so that no flag is set by accident.

// File: rtl/cc_chan_pkg.sv
package cc_chan_pkg;

    typedef enum logic [1:0] {
        ADDR_FLAGS  = 2'd0,
        ADDR_CAP_HI = 2'd1,
        ADDR_CAP_LO = 2'd2,
        ADDR_NONE   = 2'd3
    } chan_addr_e;

    localparam int FLAG_BIT_CAP = 0;
    localparam int FLAG_BIT_OVR = 1;

    typedef struct packed {
        logic ovr;
        logic cap;
    } flag_state_t;

    typedef struct packed {
        logic cap_hit;     // input-mode capture this cycle
        logic cmp_hit;     // output-mode set this cycle
        logic clr_cap_wr;  // write-zero on capture flag
        logic clr_ovr_wr;  // write-zero on overcapture flag
        logic clr_cap_rd;  // low-byte read side effect
    } chan_evt_t;

endpackage

// File: rtl/cc_chan_decode.sv
module cc_chan_decode
    import cc_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             in_mode_i,
    input  logic             cap_evt_i,
    input  logic             gen_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic [1:0]       bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [1:0]       flag_wbits_i,
    output chan_evt_t        evt_o
);

    logic sel_flags;
    logic sel_lo;

    always_comb begin
        sel_flags        = (chan_addr_e'(bus_addr_i) == ADDR_FLAGS);
        sel_lo           = (chan_addr_e'(bus_addr_i) == ADDR_CAP_LO);
        evt_o.cap_hit    = in_mode_i & (cap_evt_i | gen_i);
        evt_o.cmp_hit    = ~in_mode_i & ((cnt_i == cmp_val_i) | gen_i);
        evt_o.clr_cap_wr = bus_wr_i & sel_flags & ~flag_wbits_i[FLAG_BIT_CAP];
        evt_o.clr_ovr_wr = bus_wr_i & sel_flags & ~flag_wbits_i[FLAG_BIT_OVR];
        evt_o.clr_cap_rd = bus_rd_i & sel_lo;
    end

endmodule

// File: rtl/cc_chan_flags.sv
module cc_chan_flags
    import cc_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  chan_evt_t   evt_i,
    output flag_state_t flags_o
);

    flag_state_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (evt_i.clr_cap_wr || evt_i.clr_cap_rd)
            flags_d.cap = 1'b0;
        if (evt_i.cap_hit || evt_i.cmp_hit)
            flags_d.cap = 1'b1;
        if (evt_i.clr_ovr_wr)
            flags_d.ovr = 1'b0;
        if (evt_i.cap_hit && flags_q.cap)
            flags_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.cap_hit || evt_i.cmp_hit) |=> flags_q.cap); // R7

    AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt_i.cap_hit && flags_q.cap) && !flags_q.ovr) |=> !flags_q.ovr); // R3

    AST_LO_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.clr_cap_rd && !evt_i.cap_hit && !evt_i.cmp_hit) |=> !flags_q.cap); // R5

    AST_OVR_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i.clr_ovr_wr && flags_q.ovr) |=> flags_q.ovr); // R4

endmodule

// File: rtl/cc_chan_capreg.sv
module cc_chan_capreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o
);

    logic [CNT_W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = load_i ? cnt_i : cap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cap_q == $past(cnt_i))); // R1

endmodule

// File: rtl/cc_chan_top.sv
module cc_chan_top
    import cc_chan_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             in_mode_i,
    input  logic             cap_evt_i,
    input  logic             gen_i,
    input  logic             irq_en_i,
    input  logic [1:0]       bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o,
    output logic             cap_flag_o,
    output logic             ovr_flag_o,
    output logic             irq_o
);

    localparam int PAD_W = BUS_W - 2;

    chan_evt_t        evt;
    flag_state_t      flags;
    logic [CNT_W-1:0] cap_val;

    cc_chan_decode #(.CNT_W(CNT_W)) u_decode (
        .in_mode_i    (in_mode_i),
        .cap_evt_i    (cap_evt_i),
        .gen_i        (gen_i),
        .cnt_i        (cnt_i),
        .cmp_val_i    (cmp_val_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wr_i     (bus_wr_i),
        .bus_rd_i     (bus_rd_i),
        .flag_wbits_i (bus_wdata_i[1:0]),
        .evt_o        (evt)
    );

    cc_chan_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .flags_o (flags)
    );

    cc_chan_capreg #(.CNT_W(CNT_W)) u_capreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (evt.cap_hit),
        .cnt_i  (cnt_i),
        .cap_o  (cap_val)
    );

    always_comb begin
        case (chan_addr_e'(bus_addr_i))
            ADDR_FLAGS:  bus_rdata_o = {{PAD_W{1'b0}}, flags.ovr, flags.cap};
            ADDR_CAP_HI: bus_rdata_o = cap_val[CNT_W-1 -: BUS_W];
            ADDR_CAP_LO: bus_rdata_o = cap_val[BUS_W-1:0];
            default:     bus_rdata_o = '0;
        endcase
    end

    assign cap_flag_o = flags.cap;
    assign ovr_flag_o = flags.ovr;
    assign irq_o      = flags.cap & irq_en_i;

    AST_OUT_MODE_HOLDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_mode_i |=> $stable(cap_val)); // R2

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_mode_i && cnt_i == cmp_val_i) |=> cap_flag_o); // R2

    AST_NO_OVR_IN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_mode_i && !ovr_flag_o) |=> !ovr_flag_o); // R3

endmodule

// File: tb/test_cc_chan_top.sv
`timescale 1ns/1ps
module test_cc_chan_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic [15:0] cmp_val_i = 16'hFFFF;
    logic        in_mode_i = 1'b1;
    logic        cap_evt_i = 1'b0;
    logic        gen_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic [1:0]  bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic        cap_flag_o, ovr_flag_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cc_chan_top i_cc_chan_top (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_val_i(cmp_val_i),
        .in_mode_i(in_mode_i), .cap_evt_i(cap_evt_i), .gen_i(gen_i),
        .irq_en_i(irq_en_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
        .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .cap_flag_o(cap_flag_o), .ovr_flag_o(ovr_flag_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr_i = a;
        #0.5;
        d = bus_rdata_o;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        step();
        bus_wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        bus_addr_i = a; bus_rd_i = 1'b1;
        step();
        bus_rd_i = 1'b0;
    endtask

    task automatic capture(input logic [15:0] v);
        cnt_i = v; cap_evt_i = 1'b1;
        step();
        cap_evt_i = 1'b0;
    endtask

    task automatic clear_all();
        bus_write(2'd0, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R9 cap flag", cap_flag_o, 0);
        check("R9 ovr flag", ovr_flag_o, 0);
        check("R8 irq after reset", irq_o, 0);
        peek(2'd1, d); check("R9 cap hi", d, 0);
        peek(2'd2, d); check("R9 cap lo", d, 0);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        in_mode_i = 1'b1;
        capture(16'h1234);
        check("R1 flag set", cap_flag_o, 1);
        check("R1 no ovr", ovr_flag_o, 0);
        peek(2'd1, d); check("R10 hi byte", d, 8'h12);
        peek(2'd2, d); check("R10 lo byte", d, 8'h34);
        peek(2'd0, d); check("R10 flag reg", d, 8'h01);
        peek(2'd3, d); check("R10 unused addr", d, 8'h00);
    endtask

    task automatic t_read_clear();
        bus_read(2'd1);
        check("R5 hi read keeps flag", cap_flag_o, 1);
        bus_read(2'd2);
        check("R5 lo read clears flag", cap_flag_o, 0);
    endtask

    task automatic t_overcapture();
        logic [7:0] d;
        capture(16'h00AA);
        check("R3 first capture no ovr", ovr_flag_o, 0);
        capture(16'h5501);
        check("R3 ovr on pending capture", ovr_flag_o, 1);
        peek(2'd1, d); check("R1 hi after second", d, 8'h55);
        peek(2'd2, d); check("R1 lo after second", d, 8'h01);
        irq_en_i = 1'b1; #0.5;
        check("R8 irq enabled", irq_o, 1);
        irq_en_i = 1'b0; #0.5;
        check("R8 irq masked", irq_o, 0);
    endtask

    task automatic t_write_clear();
        bus_write(2'd0, 8'h02);
        check("R4 write0 clears cap", cap_flag_o, 0);
        check("R4 write1 keeps ovr", ovr_flag_o, 1);
        capture(16'h0001);
        bus_write(2'd0, 8'hFF);
        check("R4 all ones keeps cap", cap_flag_o, 1);
        check("R4 all ones keeps ovr", ovr_flag_o, 1);
        bus_write(2'd0, 8'h01);
        check("R4 clears ovr", ovr_flag_o, 0);
        check("R4 keeps cap", cap_flag_o, 1);
        clear_all();
    endtask

    task automatic t_set_wins();
        cnt_i = 16'h0202; cap_evt_i = 1'b1;
        bus_addr_i = 2'd0; bus_wdata_i = 8'h00; bus_wr_i = 1'b1;
        step();
        cap_evt_i = 1'b0; bus_wr_i = 1'b0;
        check("R7 capture beats write clear", cap_flag_o, 1);
        cnt_i = 16'h0303; cap_evt_i = 1'b1;
        bus_addr_i = 2'd2; bus_rd_i = 1'b1;
        step();
        cap_evt_i = 1'b0; bus_rd_i = 1'b0;
        check("R7 capture beats read clear", cap_flag_o, 1);
        check("R3 ovr with pending flag", ovr_flag_o, 1);
        clear_all();
    endtask

    task automatic t_output();
        logic [7:0] d;
        in_mode_i = 1'b0; cmp_val_i = 16'h0100; cnt_i = 16'h00FF;
        step();
        check("R2 no match no flag", cap_flag_o, 0);
        capture(16'h7777);
        check("R2 event ignored flag", cap_flag_o, 0);
        peek(2'd2, d); check("R2 capture reg held", d, 8'h03);
        cnt_i = 16'h0100;
        step();
        check("R2 match sets flag", cap_flag_o, 1);
        step();
        check("R3 no ovr in output", ovr_flag_o, 0);
        cnt_i = 16'h0101;
        clear_all();
        check("R2 cleared after match", cap_flag_o, 0);
    endtask

    task automatic t_generate();
        logic [7:0] d;
        gen_i = 1'b1; step(); gen_i = 1'b0;
        check("R6 gen in output sets flag", cap_flag_o, 1);
        check("R6 gen in output no ovr", ovr_flag_o, 0);
        peek(2'd1, d); check("R6 gen output no load", d, 8'h03);
        clear_all();
        in_mode_i = 1'b1; cnt_i = 16'h4321;
        step();
        gen_i = 1'b1; step(); gen_i = 1'b0;
        check("R6 gen input sets flag", cap_flag_o, 1);
        check("R6 gen input no ovr", ovr_flag_o, 0);
        peek(2'd1, d); check("R6 gen hi", d, 8'h43);
        peek(2'd2, d); check("R6 gen lo", d, 8'h21);
        cnt_i = 16'h4322;
        gen_i = 1'b1; step(); gen_i = 1'b0;
        check("R6 gen overcapture", ovr_flag_o, 1);
        peek(2'd2, d); check("R6 gen second lo", d, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_capture();
        t_read_clear();
        t_overcapture();
        t_write_clear();
        t_set_wins();
        t_output();
        t_generate();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule